// File: doc/BRIEF.md
# Qualified Event Counter with Threshold

This block is one performance-monitoring counter. Every cycle an event source presents a small count of events, saturated at 15. The counter passes that count through three qualifiers before adding it to a 40-bit accumulator:

- a privilege filter driven by the current privilege level;
- a filter that looks at which of two hardware threads are active;
- an optional threshold comparator, which can be inverted or reduced to rising-edge detection.

Software programs the qualifiers through a configuration write port. It can load the accumulator at any time and reads its value continuously.

Two instances can be chained into one wider count. A wrap of the lower counter emits a one-cycle carry pulse, and that pulse feeds the carry input of the upper counter. A wrap can also raise a sticky interrupt, which stays set until software next loads the counter.

Top module: `qual_event_counter`

## Requirements
- R1: After reset the counter reads 0, `irq_out` and `carry_out` are low, and the configuration is: both privilege enables on, thread mode "either", threshold mode, complement, edge, cascade and interrupt all off, threshold 0.
- R2: With threshold mode off, each cycle that passes the filters adds the full 4-bit `evt_count` to the counter. The sum is visible after the next rising clock edge.
- R3: The kernel enable permits counting at privilege level 0 and the user enable permits levels 1 to 3. A configuration write that clears both enables stores both as set.
- R4: `cfg_thread_mode` selects the thread filter over `thread_active[1:0]`: 0 counts when at least one thread is active, 1 when both are, 2 when neither is, 3 when exactly one is.
- R5: With threshold mode on, a qualifying cycle adds exactly 1. A cycle qualifies when `evt_count` is strictly greater than the threshold, or strictly less than it when complement is set. Equality never qualifies.
- R6: With threshold mode on and edge set, only a cycle whose comparison is true after a false comparison in the previous cycle adds 1. The comparison history updates every cycle, whether or not the filters pass. It is forced false by any configuration write. Edge has no effect while threshold mode is off.
- R7: A counter write loads `cnt_wdata` and clears `irq_out`, and it overrides that cycle's increment.
- R8: When the counter wraps past all-ones, `carry_out` is high for exactly the following cycle, but only if cascade is set.
- R9: A wrap with the interrupt enable set raises `irq_out`, which stays high until the next counter write.
- R10: A high `carry_in` adds 1 to that cycle's increment, independent of the filters.
- R11: A configuration write takes effect from the cycle after the write. The increment in the write cycle uses the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_os_en | input | 1 | Count at privilege level 0 |
| cfg_usr_en | input | 1 | Count at privilege levels 1-3 |
| cfg_thread_mode | input | 2 | Thread-activity filter select |
| cfg_thresh | input | 4 | Threshold value |
| cfg_thr_en | input | 1 | Threshold mode enable |
| cfg_cmpl | input | 1 | Complement the threshold comparison |
| cfg_edge | input | 1 | Count only rising comparison results |
| cfg_cascade | input | 1 | Enable carry output to partner |
| cfg_irq_en | input | 1 | Enable overflow interrupt |
| cnt_we | input | 1 | Counter load strobe |
| cnt_wdata | input | 40 | Counter load value |
| cnt_rdata | output | 40 | Current counter value |
| evt_count | input | 4 | Per-cycle event count |
| cpl | input | 2 | Current privilege level |
| thread_active | input | 2 | Activity flag per thread |
| carry_in | input | 1 | Carry pulse from partner counter |
| carry_out | output | 1 | Carry pulse to partner counter |
| irq_out | output | 1 | Sticky overflow interrupt |

## Verification
The hardest case to reach is the edge detector's hidden history. That history can be true while the counter shows nothing: the filters may have blocked the count, or the last configuration may have had edge off. The stimulus reaches it by holding a high event count through a blocked cycle, and then through a configuration rewrite. It then checks that a later high cycle adds nothing in the first case and adds 1 in the second. A wrap would take 2^40 cycles, so the bench instead loads the counter to a few below all-ones.

// File: rtl/qec_pkg.sv
package qec_pkg;
    localparam int EVT_W  = 4;
    localparam int INC_W  = EVT_W + 1;
    localparam int CPL_W  = 2;
    localparam int THR_NT = 2;

    typedef enum logic [1:0] {
        TM_EITHER  = 2'd0,
        TM_BOTH    = 2'd1,
        TM_NEITHER = 2'd2,
        TM_ONE     = 2'd3
    } thread_mode_e;

    typedef struct packed {
        logic             os_en;
        logic             usr_en;
        thread_mode_e     tmode;
        logic [EVT_W-1:0] thresh;
        logic             thr_en;
        logic             cmpl_en;
        logic             edge_en;
        logic             cascade;
        logic             irq_en;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{os_en: 1'b1, usr_en: 1'b1, tmode: TM_EITHER,
                                   thresh: '0, thr_en: 1'b0, cmpl_en: 1'b0,
                                   edge_en: 1'b0, cascade: 1'b0, irq_en: 1'b0};

    function automatic logic thread_pass(thread_mode_e m, logic [THR_NT-1:0] act);
        case (m)
            TM_EITHER:  return |act;
            TM_BOTH:    return &act;
            TM_NEITHER: return ~|act;
            default:    return ^act;
        endcase
    endfunction

    function automatic logic priv_pass(ctl_t c, logic [CPL_W-1:0] lvl);
        return (lvl == '0) ? c.os_en : c.usr_en;
    endfunction
endpackage

// File: rtl/qec_filter.sv
module qec_filter
    import qec_pkg::*;
(
    input  ctl_t              ctl,
    input  logic [CPL_W-1:0]  cpl,
    input  logic [THR_NT-1:0] thread_active,
    output logic              pass
);
    always_comb begin
        pass = priv_pass(ctl, cpl) && thread_pass(ctl.tmode, thread_active);
    end
endmodule

// File: rtl/qec_threshold.sv
module qec_threshold
    import qec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_hist,
    input  ctl_t             ctl,
    input  logic [EVT_W-1:0] evt,
    output logic             hit
);
    logic cmp;
    logic prev_q;

    always_comb begin
        cmp = ctl.cmpl_en ? (evt < ctl.thresh) : (evt > ctl.thresh);
        hit = ctl.edge_en ? (cmp && !prev_q) : cmp;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_hist) prev_q <= 1'b0;
        else                 prev_q <= cmp;
    end
endmodule

// File: rtl/qec_accum.sv
module qec_accum
    import qec_pkg::*;
#(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [INC_W-1:0] inc,
    input  logic             cascade,
    input  logic             irq_en,
    output logic [CNT_W-1:0] cnt,
    output logic             carry_out,
    output logic             irq
);
    localparam int PAD_W = CNT_W + 1 - INC_W;

    logic [CNT_W:0] sum;
    logic           wrap;

    always_comb begin
        sum  = {1'b0, cnt} + {{PAD_W{1'b0}}, inc};
        wrap = sum[CNT_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            carry_out <= 1'b0;
            irq       <= 1'b0;
        end else if (wr_en) begin
            cnt       <= wr_data;
            carry_out <= 1'b0;
            irq       <= 1'b0;
        end else begin
            cnt       <= sum[CNT_W-1:0];
            carry_out <= wrap && cascade;
            if (wrap && irq_en) irq <= 1'b1;
        end
    end
endmodule

// File: rtl/qual_event_counter.sv
module qual_event_counter
    import qec_pkg::*;
#(
    parameter int CNT_W = 40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic                 cfg_os_en,
    input  logic                 cfg_usr_en,
    input  logic [1:0]           cfg_thread_mode,
    input  logic [EVT_W-1:0]     cfg_thresh,
    input  logic                 cfg_thr_en,
    input  logic                 cfg_cmpl,
    input  logic                 cfg_edge,
    input  logic                 cfg_cascade,
    input  logic                 cfg_irq_en,
    input  logic                 cnt_we,
    input  logic [CNT_W-1:0]     cnt_wdata,
    output logic [CNT_W-1:0]     cnt_rdata,
    input  logic [EVT_W-1:0]     evt_count,
    input  logic [CPL_W-1:0]     cpl,
    input  logic [THR_NT-1:0]    thread_active,
    input  logic                 carry_in,
    output logic                 carry_out,
    output logic                 irq_out
);
    ctl_t             ctl_q;
    ctl_t             ctl_d;
    logic             filt_pass;
    logic             thr_hit;
    logic [INC_W-1:0] inc;

    always_comb begin
        ctl_d.os_en   = cfg_os_en  || !(cfg_os_en || cfg_usr_en);
        ctl_d.usr_en  = cfg_usr_en || !(cfg_os_en || cfg_usr_en);
        ctl_d.tmode   = thread_mode_e'(cfg_thread_mode);
        ctl_d.thresh  = cfg_thresh;
        ctl_d.thr_en  = cfg_thr_en;
        ctl_d.cmpl_en = cfg_cmpl;
        ctl_d.edge_en = cfg_edge;
        ctl_d.cascade = cfg_cascade;
        ctl_d.irq_en  = cfg_irq_en;
    end

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= CTL_RESET;
        else if (cfg_we) ctl_q <= ctl_d;
    end

    qec_filter u_filter (
        .ctl           (ctl_q),
        .cpl           (cpl),
        .thread_active (thread_active),
        .pass          (filt_pass)
    );

    qec_threshold u_thr (
        .clk      (clk),
        .rst      (rst),
        .clr_hist (cfg_we),
        .ctl      (ctl_q),
        .evt      (evt_count),
        .hit      (thr_hit)
    );

    always_comb begin
        inc = '0;
        if (filt_pass) begin
            if (ctl_q.thr_en) inc = {{(INC_W-1){1'b0}}, thr_hit};
            else              inc = {1'b0, evt_count};
        end
        inc = inc + {{(INC_W-1){1'b0}}, carry_in};
    end

    qec_accum #(.CNT_W(CNT_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cnt_we),
        .wr_data   (cnt_wdata),
        .inc       (inc),
        .cascade   (ctl_q.cascade),
        .irq_en    (ctl_q.irq_en),
        .cnt       (cnt_rdata),
        .carry_out (carry_out),
        .irq       (irq_out)
    );
endmodule

// File: rtl/qec_chk.sv
module qec_chk #(
    parameter int CNT_W = 40
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_we,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic [CNT_W-1:0] cnt_rdata,
    input logic             carry_out,
    input logic             irq_out,
    input logic             thr_en,
    input logic             cascade
);
    localparam logic [CNT_W-1:0] MAX_STEP = CNT_W'(16);
    localparam logic [CNT_W-1:0] THR_STEP = CNT_W'(2);

    assert_load_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> (cnt_rdata == $past(cnt_wdata)) && !irq_out);

    assert_sticky_irq_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_out && !cnt_we) |=> irq_out);

    assert_carry_after_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        carry_out |-> (cnt_rdata < MAX_STEP));

    assert_carry_gated_R8: assert property (@(posedge clk) disable iff (rst)
        carry_out |-> $past(cascade));

    assert_step_bound_R2: assert property (@(posedge clk) disable iff (rst)
        !cnt_we |=> ((cnt_rdata - $past(cnt_rdata)) <= MAX_STEP));

    assert_unit_step_R5: assert property (@(posedge clk) disable iff (rst)
        (thr_en && !cnt_we) |=> ((cnt_rdata - $past(cnt_rdata)) <= THR_STEP));
endmodule

bind qual_event_counter qec_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .cnt_rdata (cnt_rdata),
    .carry_out (carry_out),
    .irq_out   (irq_out),
    .thr_en    (ctl_q.thr_en),
    .cascade   (ctl_q.cascade)
);

// File: tb/qual_event_counter_tb.sv
`timescale 1ns/1ps
module qual_event_counter_tb;
    localparam int CW = 40;

    typedef struct {
        logic [CW-1:0] cnt;
        logic          irq;
        logic          co;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 0, cfg_os_en = 0, cfg_usr_en = 0;
    logic [1:0] cfg_thread_mode = 0;
    logic [3:0] cfg_thresh = 0;
    logic cfg_thr_en = 0, cfg_cmpl = 0, cfg_edge = 0, cfg_cascade = 0, cfg_irq_en = 0;
    logic cnt_we = 0;
    logic [CW-1:0] cnt_wdata = 0;
    logic [CW-1:0] cnt_rdata;
    logic [3:0] evt_count = 0;
    logic [1:0] cpl = 0;
    logic [1:0] thread_active = 0;
    logic carry_in = 0;
    logic carry_out, irq_out;

    always #10 clk = ~clk;

    qual_event_counter #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_os_en(cfg_os_en),
        .cfg_usr_en(cfg_usr_en), .cfg_thread_mode(cfg_thread_mode),
        .cfg_thresh(cfg_thresh), .cfg_thr_en(cfg_thr_en), .cfg_cmpl(cfg_cmpl),
        .cfg_edge(cfg_edge), .cfg_cascade(cfg_cascade), .cfg_irq_en(cfg_irq_en),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
        .evt_count(evt_count), .cpl(cpl), .thread_active(thread_active),
        .carry_in(carry_in), .carry_out(carry_out), .irq_out(irq_out)
    );

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    // model state
    logic [CW-1:0] m_cnt = 0;
    logic m_irq = 0, m_prev = 0;
    logic m_os = 1, m_usr = 1, m_thr = 0, m_cmpl = 0, m_edge = 0, m_casc = 0, m_irqen = 0;
    logic [1:0] m_tm = 0;
    logic [3:0] m_th = 0;

    // stimulus values for the next cycle
    logic [3:0] n_evt = 0;
    logic [1:0] n_cpl = 0;
    logic [1:0] n_act = 2'b01;
    logic       n_cin = 0;

    // monitor
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (cnt_rdata !== e.cnt || irq_out !== e.irq || carry_out !== e.co) begin
                errors++;
                $display("FAIL %s: actual cnt=%0d irq=%0b co=%0b expected cnt=%0d irq=%0b co=%0b",
                         e.tag, cnt_rdata, irq_out, carry_out, e.cnt, e.irq, e.co);
            end
        end
    end

    function automatic logic thr_ok(logic [1:0] m, logic [1:0] a);
        case (m)
            2'd0: return a != 2'b00;
            2'd1: return a == 2'b11;
            2'd2: return a == 2'b00;
            default: return a == 2'b01 || a == 2'b10;
        endcase
    endfunction

    task automatic drive(input logic cw, input logic nw, input logic [CW-1:0] wv, input string tag);
        logic cmp, hit, ok, co;
        logic [4:0] inc;
        logic [CW:0] sum;
        @(negedge clk);
        #1;
        cfg_we = cw; cnt_we = nw; cnt_wdata = wv;
        evt_count = n_evt; cpl = n_cpl; thread_active = n_act; carry_in = n_cin;
        cmp = m_cmpl ? (n_evt < m_th) : (n_evt > m_th);
        hit = m_edge ? (cmp && !m_prev) : cmp;
        ok  = ((n_cpl == 0) ? m_os : m_usr) && thr_ok(m_tm, n_act);
        inc = ok ? (m_thr ? {4'd0, hit} : {1'b0, n_evt}) : 5'd0;
        inc = inc + {4'd0, n_cin};
        co = 0;
        if (nw) begin
            m_cnt = wv; m_irq = 0;
        end else begin
            sum = {1'b0, m_cnt} + {{(CW-4){1'b0}}, inc};
            m_cnt = sum[CW-1:0];
            co = sum[CW] && m_casc;
            if (sum[CW] && m_irqen) m_irq = 1;
        end
        m_prev = cw ? 1'b0 : cmp;
        if (cw) begin
            m_os = cfg_os_en || !(cfg_os_en || cfg_usr_en);
            m_usr = cfg_usr_en || !(cfg_os_en || cfg_usr_en);
            m_tm = cfg_thread_mode; m_th = cfg_thresh; m_thr = cfg_thr_en;
            m_cmpl = cfg_cmpl; m_edge = cfg_edge; m_casc = cfg_cascade; m_irqen = cfg_irq_en;
        end
        q.push_back('{cnt: m_cnt, irq: m_irq, co: co, tag: tag});
    endtask

    task automatic cyc(input string tag);
        drive(1'b0, 1'b0, '0, tag);
    endtask

    task automatic wcnt(input logic [CW-1:0] v, input string tag);
        drive(1'b0, 1'b1, v, tag);
    endtask

    task automatic wcfg(input logic os, input logic usr, input logic [1:0] tm, input logic [3:0] th,
                        input logic te, input logic cm, input logic ed, input logic cs,
                        input logic ie, input string tag);
        cfg_os_en = os; cfg_usr_en = usr; cfg_thread_mode = tm; cfg_thresh = th;
        cfg_thr_en = te; cfg_cmpl = cm; cfg_edge = ed; cfg_cascade = cs; cfg_irq_en = ie;
        drive(1'b1, 1'b0, '0, tag);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        checks++;
        if (cnt_rdata !== '0 || irq_out !== 1'b0 || carry_out !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual cnt=%0d irq=%0b co=%0b expected 0 0 0", cnt_rdata, irq_out, carry_out);
        end

        // R2: raw count accumulation
        n_evt = 5; cyc("R2 add 5"); cyc("R2 add 5"); cyc("R2 add 5");
        n_evt = 15; cyc("R2 add 15");
        n_evt = 0;  cyc("R2 add 0");

        // R3: privilege filter and R11 write-cycle uses old config
        n_evt = 3;
        wcfg(1, 0, 0, 0, 0, 0, 0, 0, 0, "R11 write cycle counts old cfg");
        n_cpl = 2; cyc("R3 user level blocked");
        n_cpl = 0; cyc("R3 kernel level counts");
        wcfg(0, 1, 0, 0, 0, 0, 0, 0, 0, "R3 cfg");
        cyc("R3 kernel level blocked");
        n_cpl = 3; cyc("R3 user level counts");
        wcfg(0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 both-clear cfg");
        n_cpl = 1; cyc("R3 default user on");
        n_cpl = 0; cyc("R3 default kernel on");

        // R4: thread filter modes
        for (int m = 0; m < 4; m++) begin
            wcfg(1, 1, 2'(m), 0, 0, 0, 0, 0, 0, "R4 cfg");
            for (int a = 0; a < 4; a++) begin
                n_act = 2'(a); n_evt = 4'(a + 1);
                cyc($sformatf("R4 mode %0d act %0d", m, a));
            end
        end
        n_act = 2'b01;

        // R7: load overrides increment
        n_evt = 7; wcnt(40'd100, "R7 load wins");
        cyc("R7 counts after load");

        // R5: threshold and complement
        n_evt = 0;
        wcfg(1, 1, 0, 6, 1, 0, 0, 0, 0, "R5 cfg");
        n_evt = 6;  cyc("R5 equal not counted");
        n_evt = 7;  cyc("R5 above adds 1");
        n_evt = 15; cyc("R5 above adds 1");
        n_evt = 2;  cyc("R5 below not counted");
        wcfg(1, 1, 0, 6, 1, 1, 0, 0, 0, "R5 cmpl cfg");
        n_evt = 2;  cyc("R5 complement below adds 1");
        n_evt = 6;  cyc("R5 complement equal not counted");
        n_evt = 9;  cyc("R5 complement above not counted");

        // R6: edge detection
        n_evt = 0;
        wcfg(1, 1, 0, 4, 1, 0, 1, 0, 0, "R6 cfg");
        n_evt = 5; cyc("R6 rising adds 1"); cyc("R6 held adds 0");
        n_evt = 2; cyc("R6 low adds 0");
        n_evt = 5; cyc("R6 rising again adds 1"); cyc("R6 held again");
        n_evt = 0;
        wcfg(1, 1, 0, 4, 0, 0, 1, 0, 0, "R6 edge without thr cfg");
        n_evt = 5; cyc("R6 edge ignored thr off"); cyc("R6 edge ignored thr off");
        n_evt = 9;
        wcfg(1, 1, 0, 4, 1, 0, 1, 0, 0, "R6 write cycle old cfg");
        cyc("R6 history cleared by write adds 1");
        cyc("R6 held adds 0");
        wcfg(1, 1, 0, 4, 1, 0, 1, 0, 0, "R6 rewrite while high");
        cyc("R6 rewrite clears history adds 1");
        n_evt = 0;
        wcfg(1, 1, 1, 4, 1, 0, 1, 0, 0, "R6 both-thread cfg");
        n_evt = 9; n_act = 2'b01; cyc("R6 filtered cycle adds 0");
        n_act = 2'b11; cyc("R6 history updated while filtered adds 0");
        n_act = 2'b01;

        // R10: carry input
        n_evt = 0;
        wcfg(1, 1, 0, 0, 0, 0, 0, 0, 0, "R10 cfg");
        n_cin = 1; cyc("R10 carry alone adds 1");
        n_evt = 3; cyc("R10 carry plus events adds 4");
        n_act = 2'b00; cyc("R10 carry counts when filtered");
        n_cin = 0; n_act = 2'b01; n_evt = 0;

        // R8 / R9: wrap
        wcfg(1, 1, 0, 0, 0, 0, 0, 1, 1, "R8 cfg");
        wcnt({CW{1'b1}} - 40'd2, "R7 load near max");
        n_evt = 5; cyc("R8 R9 wrap pulses carry and irq");
        n_evt = 0; cyc("R8 carry one cycle R9 irq sticky");
        cyc("R9 irq still set");
        wcnt(40'd0, "R7 load clears irq");
        wcfg(1, 1, 0, 0, 0, 0, 0, 0, 0, "R8 no cascade cfg");
        wcnt({CW{1'b1}}, "R7 load all ones");
        n_evt = 1; cyc("R8 wrap no carry when cascade off R9 no irq");
        n_evt = 0; cyc("R8 idle");

        @(negedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule